// File: doc/BRIEF.md
# Base-Index Effective Address Generator

This block forms the effective address of a memory-reference instruction on a machine whose memory is addressed in consecutive 12-bit units. The decoder supplies three fields. The first is a one-bit base select. The second is a two-bit index select. The third is an unsigned displacement. The block puts register numbers on two read ports of the integer register file and takes back the register values. It adds base, displacement and, when indexing is on, the index register. The sum wraps modulo the address width.

The base register is always applied. The select bit only chooses which of two fixed registers is the base. Indexing is turned off only by an index field of zero. The result is registered, so it appears one cycle after a valid request. It comes out in two forms: the address in 12-bit units and the address of the 96-bit physical word that holds it. A misalignment flag comes with them. It warns when the address breaks the alignment advised for the operand size. A misaligned access is still allowed, and its address is still produced.

Top module: `agen_top`

## Requirements
- R1: After reset, `outValid`, `effAddr`, `wordAddr` and `misalign` are all zero.
- R2: `rfBaseAddr` is 6 when `baseSel` is 0 and 7 when `baseSel` is 1. The value read from that register is always added to the address.
- R3: When `indexSel` is 0, no index term is added, whatever register 0 holds. When `indexSel` is 1, 2 or 3, `rfIndexAddr` equals that number and the register value read back is added.
- R4: `effAddr` = base + zero-extended `disp` + index term, truncated to ADDR_W bits, so sums past the top of the address space wrap.
- R5: `wordAddr` equals `effAddr` shifted right by 3, which is `effAddr` divided by the eight 12-bit units in one 96-bit word.
- R6: The `opSize` codes and the low address bits they test are: 1 (24-bit integer) tests bit 0; 2 (48-bit long) and 3 (48-bit medium) test bits 1:0; 4 (96-bit extended) tests bits 2:0. `misalign` is 1 when any tested bit of the address is set. Codes 0, 5, 6 and 7 never raise the flag. The address is produced in every case.
- R7: `outValid` is high exactly in the cycle after a cycle in which `inValid` was high. Back-to-back requests produce back-to-back results, each with its own address.
- R8: While `inValid` is low, `effAddr`, `wordAddr` and `misalign` keep their last values, even when the inputs and register contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request valid; the fields below are sampled on this cycle |
| baseSel | input | 1 | Base select: 0 chooses register 6, 1 chooses register 7 |
| indexSel | input | 2 | Index select: 0 means no index, 1 to 3 name the index register |
| disp | input | DISP_W (12) | Unsigned displacement in 12-bit units |
| opSize | input | 3 | Operand size code for the alignment check |
| rfBaseAddr | output | 3 | Register number of the base read port |
| rfBaseData | input | ADDR_W (24) | Base register value returned by the register file |
| rfIndexAddr | output | 3 | Register number of the index read port |
| rfIndexData | input | ADDR_W (24) | Index register value returned by the register file |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| effAddr | output | ADDR_W (24) | Effective address in 12-bit units |
| wordAddr | output | ADDR_W-3 (21) | Address of the 96-bit physical word |
| misalign | output | 1 | Advisory alignment warning for `opSize` |

## Verification
The in-line assertions watch four things on every cycle. They check that `outValid` follows `inValid` by exactly one cycle. They check that the word address always equals the unit address shifted right by three. They check that a raised misalignment flag never goes with an address whose low three bits are zero. They check that the registered results do not move in a cycle with no request. The arithmetic itself can only be shown by the bench's scenarios. Those scenarios cover the choice of base register, the index-zero case with a nonzero register 0, wrap-around of the sum, the per-size alignment table and the independence of back-to-back results. For each of these the bench computes the expected address from its own copy of the register contents.

// File: rtl/agen_pkg.sv
package agen_pkg;

  // Operand-size codes used by the alignment check.
  typedef enum logic [2:0] {
    SZ_UNCHECKED = 3'd0,
    SZ_INT24     = 3'd1,
    SZ_LONG48    = 3'd2,
    SZ_MED48     = 3'd3,
    SZ_EXT96     = 3'd4
  } opsize_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // latch a new address this cycle
  } agen_strobe_t;

  // Low address bits that must be clear for the advised alignment.
  function automatic logic [2:0] alignMask(input logic [2:0] sizeCode);
    case (sizeCode)
      SZ_INT24:  alignMask = 3'b001;
      SZ_LONG48: alignMask = 3'b011;
      SZ_MED48:  alignMask = 3'b011;
      SZ_EXT96:  alignMask = 3'b111;
      default:   alignMask = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output agen_strobe_t strobe,
  output logic         outValid
);

  logic validQ;

  always_comb begin
    strobe = '0;
    strobe.capture = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign outValid = validQ;

  // R7: one-cycle latency, one result per request
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/agen_datapath.sv
module agen_datapath
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DISP_W     = 12,
  parameter int WORD_UNITS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  agen_strobe_t              strobe,
  input  logic [ADDR_W-1:0]         baseData,
  input  logic [ADDR_W-1:0]         indexData,
  input  logic [1:0]                indexSel,
  input  logic [DISP_W-1:0]         disp,
  input  logic [2:0]                opSize,
  output logic [ADDR_W-1:0]         effAddr,
  output logic [ADDR_W-$clog2(WORD_UNITS)-1:0] wordAddr,
  output logic                      misalign
);

  localparam int SHIFT  = $clog2(WORD_UNITS);
  localparam int WORD_W = ADDR_W - SHIFT;

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] indexTerm;
  logic [ADDR_W-1:0] sum;
  logic [2:0]        sizeMask;
  logic              badAlign;

  logic [ADDR_W-1:0] effAddrQ;
  logic [WORD_W-1:0] wordAddrQ;
  logic              misalignQ;

  always_comb begin
    dispExt   = ADDR_W'(disp);
    indexTerm = (indexSel != 2'd0) ? indexData : '0;
    sum       = baseData + dispExt + indexTerm;
    sizeMask  = alignMask(opSize);
    badAlign  = |(sum[2:0] & sizeMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effAddrQ  <= '0;
      wordAddrQ <= '0;
      misalignQ <= 1'b0;
    end else if (strobe.capture) begin
      effAddrQ  <= sum;
      wordAddrQ <= sum[ADDR_W-1:SHIFT];
      misalignQ <= badAlign;
    end
  end

  assign effAddr  = effAddrQ;
  assign wordAddr = wordAddrQ;
  assign misalign = misalignQ;

  // R5: word address tracks unit address
  assert_word_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    wordAddr == effAddr[ADDR_W-1:SHIFT]);

  // R6: a warning never accompanies a fully aligned address
  assert_misalign_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (effAddr[2:0] != 3'b000));

  // R8: results hold with no request
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(effAddr) && $stable(misalign)));

endmodule

// File: rtl/agen_top.sv
module agen_top
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DISP_W     = 12,
  parameter int WORD_UNITS = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  inValid,
  input  logic                                  baseSel,
  input  logic [1:0]                            indexSel,
  input  logic [DISP_W-1:0]                     disp,
  input  logic [2:0]                            opSize,
  output logic [2:0]                            rfBaseAddr,
  input  logic [ADDR_W-1:0]                     rfBaseData,
  output logic [2:0]                            rfIndexAddr,
  input  logic [ADDR_W-1:0]                     rfIndexData,
  output logic                                  outValid,
  output logic [ADDR_W-1:0]                     effAddr,
  output logic [ADDR_W-$clog2(WORD_UNITS)-1:0]  wordAddr,
  output logic                                  misalign
);

  agen_strobe_t strobe;

  // Base is register 6 or 7; index port follows the field directly.
  assign rfBaseAddr  = {2'b11, baseSel};
  assign rfIndexAddr = {1'b0, indexSel};

  agen_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  agen_datapath #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .WORD_UNITS (WORD_UNITS)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .baseData  (rfBaseData),
    .indexData (rfIndexData),
    .indexSel  (indexSel),
    .disp      (disp),
    .opSize    (opSize),
    .effAddr   (effAddr),
    .wordAddr  (wordAddr),
    .misalign  (misalign)
  );

endmodule

// File: tb/agen_top_test.sv
module agen_top_test;

  localparam int AW = 24;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          baseSel = 1'b0;
  logic [1:0]    indexSel = 2'd0;
  logic [DW-1:0] disp = '0;
  logic [2:0]    opSize = 3'd0;
  logic [2:0]    rfBaseAddr, rfIndexAddr;
  logic [AW-1:0] rfBaseData, rfIndexData;
  logic          outValid, misalign;
  logic [AW-1:0] effAddr;
  logic [AW-4:0] wordAddr;

  logic [AW-1:0] regs [8];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  assign rfBaseData  = regs[rfBaseAddr];
  assign rfIndexData = regs[rfIndexAddr];

  agen_top uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .baseSel(baseSel),
    .indexSel(indexSel), .disp(disp), .opSize(opSize),
    .rfBaseAddr(rfBaseAddr), .rfBaseData(rfBaseData),
    .rfIndexAddr(rfIndexAddr), .rfIndexData(rfIndexData),
    .outValid(outValid), .effAddr(effAddr), .wordAddr(wordAddr),
    .misalign(misalign)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] expEa(input logic bs, input logic [1:0] ix,
                                          input logic [DW-1:0] d);
    logic [AW-1:0] r;
    r = regs[bs ? 7 : 6] + AW'(d);
    if (ix != 2'd0) r = r + regs[ix];
    return r;
  endfunction

  function automatic logic expMis(input logic [2:0] sz, input logic [AW-1:0] a);
    case (sz)
      3'd1:    return a[0] != 1'b0;
      3'd2:    return a[1:0] != 2'b00;
      3'd3:    return a[1:0] != 2'b00;
      3'd4:    return a[2:0] != 3'b000;
      default: return 1'b0;
    endcase
  endfunction

  // Drive one request after a falling edge; check results one edge later.
  task automatic runOne(input string req, input logic bs, input logic [1:0] ix,
                        input logic [DW-1:0] d, input logic [2:0] sz);
    logic [AW-1:0] ea;
    @(negedge clk);
    baseSel = bs; indexSel = ix; disp = d; opSize = sz; inValid = 1'b1;
    ea = expEa(bs, ix, d);
    #1;
    check({req, " R2 base port"}, 32'(rfBaseAddr), bs ? 32'd7 : 32'd6);
    if (ix != 2'd0) check({req, " R3 index port"}, 32'(rfIndexAddr), 32'(ix));
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R7 outValid"}, 32'(outValid), 32'd1);
    check({req, " R4 effAddr"}, 32'(effAddr), 32'(ea));
    check({req, " R5 wordAddr"}, 32'(wordAddr), 32'(ea >> 3));
    check({req, " R6 misalign"}, 32'(misalign), 32'(expMis(sz, ea)));
  endtask

  task automatic testReset();
    check("R1 outValid", 32'(outValid), 0);
    check("R1 effAddr", 32'(effAddr), 0);
    check("R1 wordAddr", 32'(wordAddr), 0);
    check("R1 misalign", 32'(misalign), 0);
  endtask

  task automatic testBaseSelect();
    runOne("R2 base6", 1'b0, 2'd0, 12'h010, 3'd0);
    runOne("R2 base7", 1'b1, 2'd0, 12'h010, 3'd0);
  endtask

  task automatic testIndexing();
    // register 0 nonzero: index field 0 must still add nothing
    runOne("R3 idx0", 1'b0, 2'd0, 12'h123, 3'd0);
    runOne("R3 idx1", 1'b0, 2'd1, 12'h004, 3'd0);
    runOne("R3 idx2", 1'b1, 2'd2, 12'hFFF, 3'd0);
    runOne("R3 idx3", 1'b1, 2'd3, 12'h001, 3'd0);
  endtask

  task automatic testWrap();
    regs[6] = 24'hFFFFF0;
    runOne("R4 wrap", 1'b0, 2'd0, 12'h020, 3'd0);
    check("R4 wrap value", 32'(effAddr), 32'h000010);
    regs[6] = 24'h010000;
  endtask

  task automatic testAlignment();
    // base 0x010000 so the displacement sets the low bits
    for (int sz = 0; sz < 8; sz++) begin
      runOne("R6 odd", 1'b0, 2'd0, 12'h001, 3'(sz));
      runOne("R6 two", 1'b0, 2'd0, 12'h002, 3'(sz));
      runOne("R6 four", 1'b0, 2'd0, 12'h004, 3'(sz));
      runOne("R6 eight", 1'b0, 2'd0, 12'h008, 3'(sz));
    end
    runOne("R6 ext mis", 1'b0, 2'd0, 12'h004, 3'd4);
    check("R6 ext flag", 32'(misalign), 1);
    check("R6 ext addr kept", 32'(effAddr), 32'h010004);
  endtask

  task automatic testHold();
    logic [AW-1:0] held;
    runOne("R8 setup", 1'b1, 2'd1, 12'h003, 3'd1);
    held = effAddr;
    @(negedge clk);
    disp = 12'hABC; indexSel = 2'd3; opSize = 3'd4; regs[7] = 24'h123457;
    repeat (2) @(negedge clk);
    check("R8 outValid low", 32'(outValid), 0);
    check("R8 effAddr held", 32'(effAddr), 32'(held));
    check("R8 wordAddr held", 32'(wordAddr), 32'(held >> 3));
    check("R8 misalign held", 32'(misalign), 1);
    regs[7] = 24'h400000;
  endtask

  task automatic testBackToBack();
    logic [AW-1:0] a, b;
    @(negedge clk);
    baseSel = 1'b0; indexSel = 2'd1; disp = 12'h100; opSize = 3'd2; inValid = 1'b1;
    a = expEa(1'b0, 2'd1, 12'h100);
    @(negedge clk);
    check("R7 b2b first valid", 32'(outValid), 1);
    check("R7 b2b first addr", 32'(effAddr), 32'(a));
    baseSel = 1'b1; indexSel = 2'd2; disp = 12'h003; opSize = 3'd2;
    b = expEa(1'b1, 2'd2, 12'h003);
    @(negedge clk);
    inValid = 1'b0;
    check("R7 b2b second valid", 32'(outValid), 1);
    check("R7 b2b second addr", 32'(effAddr), 32'(b));
    check("R6 b2b second flag", 32'(misalign), 1);
    @(negedge clk);
    check("R7 single pulse", 32'(outValid), 0);
  endtask

  initial begin
    regs[0] = 24'h000777; regs[1] = 24'h000064; regs[2] = 24'h002000;
    regs[3] = 24'h0ABCDE; regs[4] = 24'h0; regs[5] = 24'h0;
    regs[6] = 24'h010000; regs[7] = 24'h400000;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testBaseSelect();
    testIndexing();
    testWrap();
    testAlignment();
    testHold();
    testBackToBack();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule